// File: doc/BRIEF.md
# Packed Word Multiply-Add Unit

This block is a pipelined SIMD integer multiplier for 64-bit operands. Each operand holds four 16-bit word lanes. Every lane multiplies its two signed words into a 32-bit intermediate product. An opcode then picks how the result is packed:

- the low half of each product, or
- the high half of each signed product, or
- two 32-bit sums, each built from a pair of neighbouring products.

The pair sums wrap on overflow rather than saturate.

An operation is offered with `in_valid` together with its opcode and operands. A new operation may be offered on every clock. Each result leaves on `out_data`, qualified by `out_valid`, a fixed number of cycles later (8 by default). All four multipliers serve every opcode, so only the final packing depends on the operation.

Top module: `pmac_unit`

## Requirements
- R1: Opcode 00 (multiply-low) places bits 15:0 of lane i's product in result bits [16i+15:16i]. Lane i occupies operand bits [16i+15:16i]. This value equals the low 16 bits of the unsigned product of the two words.
- R2: Opcode 01 (multiply-high) places bits 31:16 of lane i's signed (two's complement) product in result bits [16i+15:16i].
- R3: Opcode 10 (multiply-add) places the signed sum of the lane 3 and lane 2 products in result bits 63:32, and the signed sum of the lane 1 and lane 0 products in bits 31:0.
- R4: The multiply-add sums are truncated to 32 bits and never saturated. When every word of both operands is 8000h, each 32-bit half of the result is 80000000h.
- R5: Each accepted operation raises `out_valid` for exactly one cycle, 8 clock edges after the edge that samples it with `in_valid` high. No result appears without an accepted operation.
- R6: Operations offered on consecutive cycles, with mixed opcodes, each produce their own correct result on consecutive cycles, in issue order.
- R7: Opcode 11 is reserved. An accepted operation with this opcode still raises `out_valid`, with `out_data` all zeros.
- R8: While `rst_n` is low, and until the first accepted operation reaches the output, `out_valid` is 0 and `out_data` is 0.
- R9: In every cycle where `out_valid` is 0, `out_data` is all zeros. Idle cycles offered with `in_valid` low produce no result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation offered this cycle |
| in_op | input | 2 | 00 low, 01 high, 10 multiply-add, 11 reserved |
| in_a | input | 64 | First operand, four signed 16-bit words |
| in_b | input | 64 | Second operand, four signed 16-bit words |
| out_valid | output | 1 | Result present this cycle |
| out_data | output | 64 | Packed result |

## Verification
The bench checks the signed extremes: 8000h times 8000h, 7FFFh times 8000h, and -1 times -1. A multiplier that dropped sign extension would return wrong high halves and wrong pair sums, while its low halves still matched. The all-8000h multiply-add case targets a design that saturates to 7FFFFFFFh or keeps a carry, instead of wrapping to 80000000h. Back-to-back streams with mixed opcodes, and streams broken by bubbles, expose an opcode or valid bit that drifts out of step with its data. The reserved opcode and idle cycles show whether stale data leaks onto `out_data`.

// File: rtl/pmac_pkg.sv
package pmac_pkg;
  localparam int WORD_W  = 16;
  localparam int N_LANES = 4;
  localparam int PIPE_LAT = 8;

  typedef enum logic [1:0] {
    OP_MUL_LO = 2'b00,
    OP_MUL_HI = 2'b01,
    OP_MAC    = 2'b10,
    OP_RSVD   = 2'b11
  } pmac_op_e;
endpackage

// File: rtl/pmac_lane_mul.sv
module pmac_lane_mul #(
  parameter int W = 16,
  localparam int PW = 2 * W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  a,
  input  logic [W-1:0]  b,
  output logic [PW-1:0] prod_q
);
  function automatic logic [PW-1:0] smul(input logic [W-1:0] x, input logic [W-1:0] y);
    logic signed [PW-1:0] xs, ys;
    xs = PW'($signed(x));
    ys = PW'($signed(y));
    return xs * ys;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) prod_q <= '0;
    else        prod_q <= smul(a, b);
  end

  // Unsigned low-half view, independent of the signed path.
  logic [W-1:0] ulo_chk;
  logic         live_q;
  assign ulo_chk = W'(a * b);
  always_ff @(posedge clk) live_q <= rst_n;

  assert_lo_sign_agnostic_R1: assert property (@(posedge clk) disable iff (!rst_n)
    live_q |-> prod_q[W-1:0] == $past(ulo_chk));
endmodule

// File: rtl/pmac_pack.sv
module pmac_pack
  import pmac_pkg::*;
#(
  parameter int W = 16,
  parameter int LANES = 4,
  localparam int PW = 2 * W,
  localparam int DW = LANES * W,
  localparam int PAIRS = LANES / 2
) (
  input  logic                valid,
  input  pmac_op_e            op,
  input  logic [LANES*PW-1:0] prods,
  output logic [DW-1:0]       result
);
  logic [DW-1:0] lo_pack, hi_pack, mac_pack;

  function automatic logic [PW-1:0] pair_sum(input logic [PW-1:0] p, input logic [PW-1:0] q);
    logic signed [PW:0] s;
    s = (PW+1)'($signed(p)) + (PW+1)'($signed(q));
    return s[PW-1:0];
  endfunction

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lo_pack[i*W +: W] = prods[i*PW +: W];
    assign hi_pack[i*W +: W] = prods[i*PW+W +: W];
  end

  for (genvar j = 0; j < PAIRS; j++) begin : g_pair
    assign mac_pack[j*PW +: PW] = pair_sum(prods[(2*j)*PW +: PW], prods[(2*j+1)*PW +: PW]);
  end

  always_comb begin
    result = '0;
    if (valid) begin
      unique case (op)
        OP_MUL_LO: result = lo_pack;
        OP_MUL_HI: result = hi_pack;
        OP_MAC:    result = mac_pack;
        default:   result = '0;
      endcase
    end
  end
endmodule

// File: rtl/pmac_delay.sv
module pmac_delay #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  if (DEPTH == 0) begin : g_pass
    assign q = d;
  end else begin : g_chain
    logic [WIDTH-1:0] stg [DEPTH];
    for (genvar i = 0; i < DEPTH; i++) begin : g_stg
      always_ff @(posedge clk) begin
        if (!rst_n)      stg[i] <= '0;
        else if (i == 0) stg[i] <= d;
        else             stg[i] <= stg[(i == 0) ? 0 : i-1];
      end
    end
    assign q = stg[DEPTH-1];
  end
endmodule

// File: rtl/pmac_unit.sv
module pmac_unit
  import pmac_pkg::*;
#(
  parameter int W = WORD_W,
  parameter int LANES = N_LANES,
  parameter int LAT = PIPE_LAT,
  localparam int PW = 2 * W,
  localparam int DW = LANES * W,
  localparam int CW = $clog2(LAT + 2) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [1:0]    in_op,
  input  logic [63:0]   in_a,
  input  logic [63:0]   in_b,
  output logic          out_valid,
  output logic [63:0]   out_data
);
  // Stage 1: products, opcode and valid.
  logic [LANES*PW-1:0] prods;
  logic                s1_valid;
  pmac_op_e            s1_op;

  for (genvar i = 0; i < LANES; i++) begin : g_mul
    pmac_lane_mul #(.W(W)) u_mul (
      .clk(clk), .rst_n(rst_n),
      .a(in_a[i*W +: W]), .b(in_b[i*W +: W]),
      .prod_q(prods[i*PW +: PW])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_op    <= OP_MUL_LO;
    end else begin
      s1_valid <= in_valid;
      s1_op    <= pmac_op_e'(in_op);
    end
  end

  // Stage 2: packed result.
  logic [DW-1:0] packed_res, res_q;
  logic          v2_q;

  pmac_pack #(.W(W), .LANES(LANES)) u_pack (
    .valid(s1_valid), .op(s1_op), .prods(prods), .result(packed_res)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_q <= '0;
      v2_q  <= 1'b0;
    end else begin
      res_q <= packed_res;
      v2_q  <= s1_valid;
    end
  end

  // Remaining stages: plain delay to reach the total latency.
  logic [DW:0] tail_q;
  pmac_delay #(.WIDTH(DW + 1), .DEPTH(LAT - 2)) u_tail (
    .clk(clk), .rst_n(rst_n), .d({v2_q, res_q}), .q(tail_q)
  );

  assign out_valid = tail_q[DW];
  assign out_data  = tail_q[DW-1:0];

  // Observation wires for the assertions.
  logic          live_q;
  logic [CW-1:0] inflight_q;
  logic          wrap_case;
  logic [DW-1:0] wrap_word;

  always_ff @(posedge clk) begin
    live_q <= rst_n;
    if (!rst_n) inflight_q <= '0;
    else        inflight_q <= inflight_q + CW'(in_valid) - CW'(out_valid);
  end

  assign wrap_case = s1_valid && (s1_op == OP_MAC) &&
                     (prods == {LANES{1'b0, 1'b1, (PW-2)'(0)}});
  assign wrap_word = {(LANES/2){1'b1, (PW-1)'(0)}};

  assert_rsvd_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    live_q && s1_valid && s1_op == OP_RSVD |=> v2_q && res_q == '0);

  assert_mac_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    live_q && wrap_case |=> res_q == wrap_word);

  assert_idle_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> out_data == '0);

  assert_inflight_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    inflight_q <= CW'(LAT));

  assert_no_phantom_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> inflight_q != '0);
endmodule

// File: tb/tb_pmac_unit.sv
`timescale 1ns/1ps
module tb_pmac_unit;
  localparam int LAT = 8;
  localparam int HN  = 32;

  logic        clk = 0;
  logic        rst_n;
  logic        in_valid;
  logic [1:0]  in_op;
  logic [63:0] in_a, in_b;
  logic        out_valid;
  logic [63:0] out_data;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit         hv [HN];
  logic [63:0] hd [HN];
  string      ht [HN];

  always #2 clk = ~clk;

  pmac_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_data(out_data)
  );

  function automatic logic [63:0] model(logic [1:0] op, logic [63:0] a, logic [63:0] b);
    longint p [4];
    logic [63:0] r = '0;
    for (int i = 0; i < 4; i++) begin
      longint sa = longint'($signed(a[i*16 +: 16]));
      longint sb = longint'($signed(b[i*16 +: 16]));
      p[i] = sa * sb;
    end
    case (op)
      2'b00: for (int i = 0; i < 4; i++) begin
        longint ua = longint'(a[i*16 +: 16]);
        longint ub = longint'(b[i*16 +: 16]);
        longint up = ua * ub;
        r[i*16 +: 16] = up[15:0];
      end
      2'b01: for (int i = 0; i < 4; i++) begin
        longint sh = p[i] >>> 16;
        r[i*16 +: 16] = sh[15:0];
      end
      2'b10: begin
        longint s0 = p[0] + p[1];
        longint s1 = p[2] + p[3];
        r = {s1[31:0], s0[31:0]};
      end
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_out();
    int k = (cyc + HN - LAT) % HN;
    bit ev = (cyc >= LAT) ? hv[k] : 1'b0;
    logic [63:0] ed = ev ? hd[k] : 64'h0;
    string tg = ev ? ht[k] : "R9";
    check({tg, " valid"}, {63'h0, out_valid}, {63'h0, ev});
    check({tg, " data"}, out_data, ed);
  endtask

  task automatic step(bit v, logic [1:0] op, logic [63:0] a, logic [63:0] b, string tag);
    @(negedge clk);
    check_out();
    in_valid = v; in_op = op; in_a = a; in_b = b;
    hv[cyc % HN] = v;
    hd[cyc % HN] = model(op, a, b);
    ht[cyc % HN] = tag;
    cyc++;
  endtask

  task automatic drain();
    for (int i = 0; i < LAT + 1; i++) step(1'b0, 2'b00, 64'h0, 64'h0, "R9");
  endtask

  task automatic t_reset();
    rst_n = 0; in_valid = 1; in_op = 2'b10;
    in_a = 64'hFFFF_FFFF_FFFF_FFFF; in_b = 64'h1234_5678_9ABC_DEF0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R8 reset valid", {63'h0, out_valid}, 64'h0);
    check("R8 reset data", out_data, 64'h0);
    rst_n = 1; in_valid = 0;
    for (int i = 0; i < HN; i++) hv[i] = 0;
    cyc = 0;
    for (int i = 0; i < LAT; i++) begin
      @(negedge clk);
      check("R8 post-reset valid", {63'h0, out_valid}, 64'h0);
    end
  endtask

  task automatic t_low();
    step(1, 2'b00, 64'hFFFF_8000_7FFF_0003, 64'hFFFF_8000_8000_0005, "R1 low");
    step(1, 2'b00, 64'h1234_ABCD_0100_FFFE, 64'h5678_00FF_0100_0002, "R1 low");
    drain();
  endtask

  task automatic t_high();
    step(1, 2'b01, 64'hFFFF_8000_7FFF_0003, 64'hFFFF_8000_8000_0005, "R2 high");
    step(1, 2'b01, 64'h7FFF_C000_1234_FFFE, 64'h7FFF_0004_4321_7FFF, "R2 high");
    drain();
  endtask

  task automatic t_mac();
    step(1, 2'b10, 64'h0002_0003_0004_0005, 64'h0006_0007_0008_0009, "R3 mac");
    step(1, 2'b10, 64'h7FFF_8000_FFFF_0001, 64'h7FFF_7FFF_0001_FFFF, "R3 mac");
    drain();
  endtask

  task automatic t_wrap();
    step(1, 2'b10, 64'h8000_8000_8000_8000, 64'h8000_8000_8000_8000, "R4 wrap");
    drain();
  endtask

  task automatic t_rsvd();
    step(1, 2'b11, 64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888, "R7 rsvd");
    drain();
  endtask

  task automatic t_stream();
    logic [63:0] a = 64'h0123_4567_89AB_CDEF;
    logic [63:0] b = 64'hFEDC_BA98_7654_3210;
    for (int i = 0; i < 24; i++) begin
      step(1, 2'(i % 4), a, b, "R6 stream");
      a = {a[50:0], a[63:51]} ^ 64'h9E37_79B9_7F4A_7C15;
      b = {b[8:0], b[63:9]} + 64'h0000_0001_0001_0003;
    end
    drain();
  endtask

  task automatic t_gaps();
    for (int i = 0; i < 12; i++)
      step(i % 3 == 1, 2'(i % 3), {4{16'(i * 4099)}}, {4{16'(16'hF00D - i)}}, "R5 gaps");
    drain();
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    in_valid = 0; in_op = 0; in_a = 0; in_b = 0; rst_n = 0;
    t_reset();
    t_low();
    t_high();
    t_mac();
    t_wrap();
    t_rsvd();
    t_stream();
    t_gaps();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule